// File: doc/BRIEF.md
# Clock Start-Up Sequencer

This block holds the core stalled until its clock source can be trusted. It reads a 4-bit oscillator-select setting and a 2-bit start-up setting. From these it builds a delay with two phases. The first phase is an optional real-time wait, counted on a slow watchdog oscillator clock that is separate from the system clock. The second phase is a count of system clock cycles. When the second phase ends, the block raises `run_en` and the core may run.

The full delay applies when the block leaves reset. A wake from power-down runs only the short system-clock count. The block also gives the start-up system clock prescale: divide by 8 when the divide-by-8 setting is programmed. Every setting bit is active-low in meaning, so 0 means programmed and 1 means unprogrammed. The settings are static strap values. A setting code that is reserved parks the block in an error state.

Top module: `clk_start_seq`

## Requirements
- R1: Oscillator selects 0000 (external clock), 0010, 0100 and 0110 (internal oscillators) use one timing table. The start-up count is `PD_RC` cycles. Start-up code 00 adds no real-time wait, 01 adds `RT_A` watchdog cycles and 10 adds `RT_B` watchdog cycles. When there is no real-time wait, `run_en` first reads high after the 3+`PD_RC`+`RST_EXTRA`-th system clock edge after `rst_n` rises.
- R2: Oscillator selects 0001, 0011, 0101 and 0111 are reserved, and so is start-up code 11 in the internal-oscillator table. For any of these, `cfg_err` rises, `run_en` stays low, and both hold until the next reset.
- R3: For oscillator selects 1xxx (crystal or resonator), the option is {cksel[0], sut[1:0]}. Options 0 and 1 give a start-up count of `XT_A` cycles. Options 2 to 4 give `XT_B` cycles. Options 5 to 7 give `XT_C` cycles.
- R4: For crystal options, the real-time wait follows the option. Options 0, 3 and 6 wait `RT_A` watchdog cycles. Options 1, 4 and 7 wait `RT_B` watchdog cycles. Options 2 and 5 have no wait.
- R5: From reset, the system-clock count is the start-up count plus `RST_EXTRA`. It begins only after the real-time wait has finished and that result has passed through a two-flop synchronizer.
- R6: A `wake_req` pulse while `run_en` is high drops `run_en` at the next edge. `run_en` then stays low for exactly the start-up count of system cycles, with no real-time wait.
- R7: `wake_req` has no effect while the sequence is still counting or in the error state.
- R8: While `rst_n` is low, `run_en` and `cfg_err` are low at once and `clk_div8` is 1. After release, a complete sequence runs again from the start.
- R9: `clk_div8` is set to the inverse of `ckdiv8_n` at the start of each reset sequence. It does not change while `run_en` is high.
- R10: Once high, `run_en` stays high until a `wake_req` or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| wdt_clk | input | 1 | Slow watchdog oscillator clock, asynchronous to sys_clk |
| rst_n | input | 1 | Power-on/external reset request, active low, asynchronous |
| wake_req | input | 1 | Wake-from-power-down pulse, sys_clk domain |
| cksel | input | 4 | Oscillator-select setting (0 = programmed) |
| sut | input | 2 | Start-up-time setting |
| ckdiv8_n | input | 1 | Divide-by-8 setting, 0 = programmed |
| run_en | output | 1 | Core may execute |
| cfg_err | output | 1 | Reserved setting code detected |
| clk_div8 | output | 1 | Start-up prescale is divide by 8 |

## Verification
Every setting is swept, and so is each divide-by-8 value. Most internal faults show up as a change in the number of system edges between reset release and `run_en`. A wrong decode entry, a counter that is off by one or a skipped synchronizer stage shifts that count exactly when there is no real-time wait. It shifts it by a whole watchdog window when there is one. A broken restart path shows on the first wake after start-up, as a wrong length of the low window. A reserved code that slips through shows within a few cycles of release, because `run_en` rises instead of `cfg_err`.

// File: rtl/csq_pkg.sv
package csq_pkg;
  typedef enum logic [1:0] {
    RT_NONE  = 2'd0,
    RT_SHORT = 2'd1,
    RT_LONG  = 2'd2
  } rt_sel_e;

  typedef enum logic [2:0] {
    ST_CHECK  = 3'd0,
    ST_RTWAIT = 3'd1,
    ST_COUNT  = 3'd2,
    ST_RUN    = 3'd3,
    ST_ERR    = 3'd4
  } seq_state_e;
endpackage

// File: rtl/csq_rst_sync.sv
module csq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/csq_sync2.sv
module csq_sync2 (
  input  logic clk,
  input  logic srst_n,
  input  logic d,
  output logic q
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], d};
  end

  assign q = sync_q[1];
endmodule

// File: rtl/csq_decode.sv
module csq_decode
  import csq_pkg::*;
#(
  parameter int PD_RC = 6,
  parameter int XT_A  = 258,
  parameter int XT_B  = 1024,
  parameter int XT_C  = 16384,
  parameter int CNT_W = 15
) (
  input  logic [3:0]       cksel,
  input  logic [1:0]       sut,
  output logic             reserved,
  output rt_sel_e          rt_sel,
  output logic [CNT_W-1:0] startup
);
  logic [2:0] xt_opt;

  assign xt_opt = {cksel[0], sut};

  always_comb begin
    reserved = 1'b0;
    rt_sel   = RT_NONE;
    startup  = CNT_W'(PD_RC);
    if (cksel[3]) begin
      // crystal / resonator: combined option code
      case (xt_opt)
        3'd0, 3'd1:       startup = CNT_W'(XT_A);
        3'd2, 3'd3, 3'd4: startup = CNT_W'(XT_B);
        default:          startup = CNT_W'(XT_C);
      endcase
      case (xt_opt)
        3'd0, 3'd3, 3'd6: rt_sel = RT_SHORT;
        3'd1, 3'd4, 3'd7: rt_sel = RT_LONG;
        default:          rt_sel = RT_NONE;
      endcase
    end else if (cksel[0]) begin
      reserved = 1'b1;
    end else begin
      case (sut)
        2'b00:   rt_sel = RT_NONE;
        2'b01:   rt_sel = RT_SHORT;
        2'b10:   rt_sel = RT_LONG;
        default: reserved = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/csq_rt_timer.sv
module csq_rt_timer
  import csq_pkg::*;
#(
  parameter int RT_A = 4096,
  parameter int RT_B = 65536,
  parameter int RT_W = 17
) (
  input  logic    wdt_clk,
  input  logic    srst_n,
  input  rt_sel_e rt_sel,
  output logic    rt_done
);
  logic [RT_W-1:0] cnt_q, cnt_d, target;
  logic            done_q, done_d, cnt_en;

  assign target = (rt_sel == RT_LONG) ? RT_W'(RT_B) : RT_W'(RT_A);
  assign cnt_en = !done_q;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (cnt_en) begin
      cnt_d = cnt_q + RT_W'(1);
      if (cnt_q == target - RT_W'(1)) done_d = 1'b1;
    end
  end

  always_ff @(posedge wdt_clk or negedge srst_n) begin
    if (!srst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign rt_done = done_q;
endmodule

// File: rtl/clk_start_seq.sv
module clk_start_seq
  import csq_pkg::*;
#(
  parameter int PD_RC     = 6,
  parameter int RST_EXTRA = 14,
  parameter int XT_A      = 258,
  parameter int XT_B      = 1024,
  parameter int XT_C      = 16384,
  parameter int RT_A      = 4096,
  parameter int RT_B      = 65536
) (
  input  logic       sys_clk,
  input  logic       wdt_clk,
  input  logic       rst_n,
  input  logic       wake_req,
  input  logic [3:0] cksel,
  input  logic [1:0] sut,
  input  logic       ckdiv8_n,
  output logic       run_en,
  output logic       cfg_err,
  output logic       clk_div8
);
  localparam int CNT_W = $clog2(XT_C + RST_EXTRA + 1);
  localparam int RT_W  = $clog2(RT_B + 1);

  logic             sys_srst_n, wdt_srst_n;
  logic             reserved, rt_done_w, rt_done_s;
  rt_sel_e          rt_sel;
  logic [CNT_W-1:0] startup;
  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             div8_q, div8_d;

  csq_rst_sync u_sys_rst (.clk(sys_clk), .arst_n(rst_n), .srst_n(sys_srst_n));
  csq_rst_sync u_wdt_rst (.clk(wdt_clk), .arst_n(rst_n), .srst_n(wdt_srst_n));

  csq_decode #(
    .PD_RC(PD_RC), .XT_A(XT_A), .XT_B(XT_B), .XT_C(XT_C), .CNT_W(CNT_W)
  ) u_dec (
    .cksel(cksel), .sut(sut), .reserved(reserved), .rt_sel(rt_sel), .startup(startup)
  );

  csq_rt_timer #(.RT_A(RT_A), .RT_B(RT_B), .RT_W(RT_W)) u_rt (
    .wdt_clk(wdt_clk), .srst_n(wdt_srst_n), .rt_sel(rt_sel), .rt_done(rt_done_w)
  );

  csq_sync2 u_rt_sync (.clk(sys_clk), .srst_n(sys_srst_n), .d(rt_done_w), .q(rt_done_s));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    div8_d  = div8_q;
    case (state_q)
      ST_CHECK: begin
        div8_d = ~ckdiv8_n;
        if (reserved) begin
          state_d = ST_ERR;
        end else if (rt_sel == RT_NONE) begin
          state_d = ST_COUNT;
          cnt_d   = startup + CNT_W'(RST_EXTRA);
        end else begin
          state_d = ST_RTWAIT;
        end
      end
      ST_RTWAIT: begin
        if (rt_done_s) begin
          state_d = ST_COUNT;
          cnt_d   = startup + CNT_W'(RST_EXTRA);
        end
      end
      ST_COUNT: begin
        if (cnt_q <= CNT_W'(1)) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_RUN: begin
        if (wake_req) begin
          state_d = ST_COUNT;
          cnt_d   = startup;
        end
      end
      default: state_d = ST_ERR;
    endcase
  end

  always_ff @(posedge sys_clk or negedge sys_srst_n) begin
    if (!sys_srst_n) begin
      state_q <= ST_CHECK;
      cnt_q   <= '0;
      div8_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      div8_q  <= div8_d;
    end
  end

  assign run_en   = (state_q == ST_RUN);
  assign cfg_err  = (state_q == ST_ERR);
  assign clk_div8 = div8_q;
endmodule

// File: rtl/csq_chk.sv
module csq_chk #(
  parameter int CNT_W = 15
) (
  input logic             sys_clk,
  input logic             rst_n,
  input logic             wake_req,
  input logic             run_en,
  input logic             cfg_err,
  input logic             clk_div8,
  input logic [CNT_W-1:0] cnt_q
);
  // R2
  cfg_blocks_run_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    cfg_err |-> !run_en);
  // R2
  cfg_sticky_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  // R6
  wake_restart_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (run_en && wake_req) |=> !run_en);
  // R10
  run_hold_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (run_en && !wake_req) |=> run_en);
  // R9
  div8_stable_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    run_en |-> $stable(clk_div8));
  // R5
  count_end_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $rose(run_en) |-> ($past(cnt_q) == CNT_W'(1)));
endmodule

bind clk_start_seq csq_chk #(.CNT_W(CNT_W)) chk_i (
  .sys_clk(sys_clk), .rst_n(rst_n), .wake_req(wake_req), .run_en(run_en),
  .cfg_err(cfg_err), .clk_div8(clk_div8), .cnt_q(cnt_q)
);

// File: tb/clk_start_seq_tb_top.sv
module clk_start_seq_tb_top;
  localparam int SYS_PERIOD = 10;
  localparam int WDT_PERIOD = 30;
  localparam int P_RC = 6, P_EX = 14, P_XA = 25, P_XB = 40, P_XC = 70;
  localparam int P_RA = 8, P_RB = 20;

  logic sys_clk = 1'b0, wdt_clk = 1'b0;
  logic rst_n, wake_req, ckdiv8_n;
  logic [3:0] cksel;
  logic [1:0] sut;
  logic run_en, cfg_err, clk_div8;
  int checks = 0, errors = 0, cyc = 0;

  always #(SYS_PERIOD/2) sys_clk = ~sys_clk;
  always #(WDT_PERIOD/2) wdt_clk = ~wdt_clk;

  clk_start_seq #(
    .PD_RC(P_RC), .RST_EXTRA(P_EX), .XT_A(P_XA), .XT_B(P_XB), .XT_C(P_XC),
    .RT_A(P_RA), .RT_B(P_RB)
  ) dut_i (
    .sys_clk(sys_clk), .wdt_clk(wdt_clk), .rst_n(rst_n), .wake_req(wake_req),
    .cksel(cksel), .sut(sut), .ckdiv8_n(ckdiv8_n),
    .run_en(run_en), .cfg_err(cfg_err), .clk_div8(clk_div8)
  );

  always @(posedge sys_clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected timing from the requirement tables
  task automatic expect_cfg(input logic [3:0] c, input logic [1:0] s,
                            output bit res, output int rt, output int st);
    int opt;
    res = 0; rt = 0; st = P_RC;
    if (c[3]) begin
      opt = {c[0], s};
      st = (opt < 2) ? P_XA : (opt < 5) ? P_XB : P_XC;
      rt = (opt % 3 == 0) ? P_RA : (opt % 3 == 1) ? P_RB : 0;
    end else if (c[0] || s == 2'b11) res = 1;
    else rt = (s == 2'b01) ? P_RA : (s == 2'b10) ? P_RB : 0;
  endtask

  // release reset and count edges until run_en or cfg_err; optional wake pulse
  task automatic measure(input int wake_at, output int k);
    k = 0;
    rst_n = 1'b1;
    do begin
      wake_req = (k == wake_at);
      @(posedge sys_clk); k++;
      @(negedge sys_clk);
    end while (!run_en && !cfg_err && k < 3000);
    wake_req = 1'b0;
  endtask

  task automatic run_cfg(input logic [3:0] c, input logic [1:0] s, input logic d);
    bit res; int rt, st, k, n, lo, hi;
    expect_cfg(c, s, res, rt, st);
    @(negedge sys_clk);
    rst_n = 1'b0; cksel = c; sut = s; ckdiv8_n = d; wake_req = 1'b0;
    repeat (3) @(negedge sys_clk);
    chk(!run_en && !cfg_err && clk_div8, "R8 reset state", {run_en, cfg_err, clk_div8}, 1);
    measure(-1, k);
    if (res) begin
      repeat (3) @(negedge sys_clk);
      chk(cfg_err && !run_en, "R2 reserved", {cfg_err, run_en}, 2);
      wake_req = 1'b1; @(negedge sys_clk); wake_req = 1'b0;
      repeat (4) @(negedge sys_clk);
      chk(cfg_err && !run_en, "R7 wake in error", {cfg_err, run_en}, 2);
    end else begin
      if (rt == 0) begin
        chk(k == 3 + st + P_EX, c[3] ? "R3 reset count" : "R1 reset count", k, 3 + st + P_EX);
      end else begin
        lo = rt * 3 + st + P_EX;
        hi = (rt + 4) * 3 + st + P_EX + 8;
        chk(k >= lo && k <= hi, c[3] ? "R4 real-time window" : "R1 real-time window", k, lo);
      end
      chk(clk_div8 == ~d, "R9 prescale", clk_div8, ~d);
      for (int i = 0; i < 5; i++) begin
        @(negedge sys_clk);
        chk(run_en, "R10 run held", run_en, 1);
      end
      wake_req = 1'b1; @(negedge sys_clk); wake_req = 1'b0;
      n = 0;
      while (!run_en && n < 5000) begin n++; @(negedge sys_clk); end
      chk(n == st, "R6 wake count", n, st);
    end
  endtask

  initial begin
    int k;
    rst_n = 1'b0; wake_req = 1'b0; cksel = 4'b0100; sut = 2'b10; ckdiv8_n = 1'b0;
    for (int c = 0; c < 16; c++)
      for (int s = 0; s < 4; s++)
        for (int d = 0; d < 2; d++)
          run_cfg(4'(c), 2'(s), 1'(d));

    // R7: wake during the count is ignored
    @(negedge sys_clk); rst_n = 1'b0; cksel = 4'b0010; sut = 2'b00;
    repeat (3) @(negedge sys_clk);
    measure(8, k);
    chk(k == 3 + P_RC + P_EX, "R7 wake while counting", k, 3 + P_RC + P_EX);

    // R8: reset while running drops run_en at once, then full sequence again
    @(negedge sys_clk); rst_n = 1'b0; #1;
    chk(!run_en, "R8 abort from run", run_en, 0);
    repeat (2) @(negedge sys_clk);
    measure(-1, k);
    repeat (5) @(negedge sys_clk);
    rst_n = 1'b0; #1;
    chk(!run_en, "R8 abort mid count", run_en, 0);
    repeat (2) @(negedge sys_clk);
    measure(-1, k);
    chk(k == 3 + P_RC + P_EX, "R8 restart count", k, 3 + P_RC + P_EX);

    // R5: shipped default, long real-time wait must precede the clock count
    @(negedge sys_clk); rst_n = 1'b0; cksel = 4'b0100; sut = 2'b10; ckdiv8_n = 1'b0;
    repeat (3) @(negedge sys_clk);
    measure(-1, k);
    chk(k >= P_RB * 3 + P_RC + P_EX, "R5 ordered phases", k, P_RB * 3 + P_RC + P_EX);
    chk(clk_div8 == 1'b1, "R9 default divide", clk_div8, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule